// File: doc/BRIEF.md
# Time Alarm Comparator with Wildcards

This block watches the current time of day, held as three bytes (seconds, minutes, hours), and compares it with three alarm bytes each time the time keeper finishes an increment and pulses a one-cycle compare strobe. When every alarm byte that takes part in the comparison equals its time byte, a sticky alarm flag is raised. It stays raised until software-side logic pulses a clear strobe. The interrupt request output is the flag gated by an enable input.

An alarm byte whose two most significant bits are both set is a wildcard, and it drops out of the comparison. Wildcards on the upper fields turn the single comparator into a programmable-rate alarm. With no wildcard it fires once a day. A wildcard hour makes it fire once an hour. Wildcard hour and minute make it fire once a minute, and three wildcards make it fire on every compare strobe, which is once a second. Time counting and register access sit outside this block.

Top module: `alarm_cmp`

## Requirements
- R1: Field positions: bits [7:0] of `time_bytes` and `alarm_bytes` hold seconds, bits [15:8] hold minutes and bits [23:16] hold hours. Each alarm byte is compared only with the time byte in the same position.
- R2: An alarm byte with bits [7:6] equal to 2'b11 is a wildcard and is excluded from the comparison. A byte with only one of those two bits set is compared normally.
- R3: When `cmp_stb` is 1 at a rising clock edge and every non-wildcard alarm byte equals its time byte, `alm_flag` is 1 from that edge on.
- R4: With `cmp_stb` at 0, matching bytes do not set `alm_flag`.
- R5: A compare strobe that finds a mismatch leaves `alm_flag` unchanged, including when it is already 1.
- R6: `alm_flag` stays 1 until `clr_stb` is 1 at a rising edge, and it reads 0 after that edge.
- R7: When `clr_stb` and a matching compare strobe arrive at the same edge, `alm_flag` is 1 after that edge.
- R8: `alm_irq` equals `alm_flag` AND `alm_en` without a register delay. Raising `alm_en` while the flag is set asserts `alm_irq` at once.
- R9: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears `alm_flag`.
- R10: The alarm rates follow from the wildcards. No wildcard needs hours, minutes and seconds to match, a wildcard hour needs minutes and seconds to match, wildcard hours and minutes need only the seconds to match, and three wildcards match on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_bytes | input | 24 | Current {hours, minutes, seconds} |
| alarm_bytes | input | 24 | Alarm {hours, minutes, seconds}, a byte with top bits 11 is a wildcard |
| cmp_stb | input | 1 | One-cycle compare strobe, issued after the time bytes settle |
| alm_en | input | 1 | Interrupt enable |
| clr_stb | input | 1 | One-cycle flag clear strobe |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_irq | output | 1 | Interrupt request, the flag gated by the enable |

## Verification
The bench builds the block with its default parameters: three fields of eight bits, with the wildcard code in bits [7:6]. This width reaches the hour, minute and second patterns of every alarm rate, and it also reaches the near-wildcard codes 8'h80 and 8'h40, which must still be compared. Directed sequences then check the flag's memory across strobes with no match, without a strobe, and under a clear and a match that arrive together.

// File: rtl/alarm_cmp_pkg.sv
// Package: shared constants and the wildcard decode for the alarm comparator.
// Assumes the wildcard code sits in the two most significant bits of a byte.
package alarm_cmp_pkg;

    localparam int unsigned WILD_CODE_W = 2;

    // Decide whether the top bits of an alarm byte mark it as a wildcard.
    function automatic logic is_wildcard(input logic [WILD_CODE_W-1:0] top_bits);
        return &top_bits;
    endfunction

endpackage

// File: rtl/alarm_field_match.sv
// Module: compares one alarm byte with one time byte.
// hit is 1 when the bytes are equal or the alarm byte is a wildcard.
// Assumes BYTE_W >= 2. Purely combinational.
module alarm_field_match
    import alarm_cmp_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] time_byte,
    input  logic [BYTE_W-1:0] alarm_byte,
    output logic              hit
);

    localparam int unsigned TOP = BYTE_W - 1;

    logic wild;

    // Decode the wildcard and form the per-field match.
    always_comb begin
        wild = is_wildcard(alarm_byte[TOP -: WILD_CODE_W]);
        hit  = wild || (time_byte == alarm_byte);
    end

    // R2: a wildcard byte never blocks the match, whatever the time byte holds.
    always_comb begin
        assert_wild_hit_R2: assert (!(&alarm_byte[TOP -: WILD_CODE_W]) || hit)
            else $error("wildcard field did not hit");
    end

endmodule

// File: rtl/alarm_flag_reg.sv
// Module: the sticky alarm flag.
// A strobe that finds a match sets the flag. A clear strobe clears it, but a
// set at the same edge wins. Synchronous active-low reset.
module alarm_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_stb,
    input  logic all_hit,
    input  logic clr_stb,
    output logic flag
);

    logic set_req;

    // Qualify the match with the compare strobe.
    always_comb set_req = cmp_stb && all_hit;

    // Update the flag: a set beats a clear, and otherwise the flag holds.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_stb) flag <= 1'b0;
    end

    assert_set_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && all_hit) |=> flag);

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_stb && !clr_stb) |=> $stable(flag));

    assert_miss_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && !all_hit && !clr_stb) |=> $stable(flag));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !(cmp_stb && all_hit)) |=> !flag);

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> !flag);

endmodule

// File: rtl/alarm_cmp.sv
// Module: the top level of the time alarm comparator.
// One matcher is built for each time field. The flag register records a
// strobed match, and the interrupt request is the flag gated by the enable.
// Field 0 is seconds, field 1 is minutes and field 2 is hours.
module alarm_cmp #(
    parameter int unsigned NUM_FIELDS = 3,
    parameter int unsigned BYTE_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FIELDS*BYTE_W-1:0] time_bytes,
    input  logic [NUM_FIELDS*BYTE_W-1:0] alarm_bytes,
    input  logic                         cmp_stb,
    input  logic                         alm_en,
    input  logic                         clr_stb,
    output logic                         alm_flag,
    output logic                         alm_irq
);

    logic [NUM_FIELDS-1:0] field_hit;
    logic                  all_hit;

    // Build one comparator for each time field.
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        alarm_field_match #(.BYTE_W(BYTE_W)) u_match (
            .time_byte  (time_bytes [f*BYTE_W +: BYTE_W]),
            .alarm_byte (alarm_bytes[f*BYTE_W +: BYTE_W]),
            .hit        (field_hit[f])
        );
    end

    // Require every field to hit.
    always_comb all_hit = &field_hit;

    alarm_flag_reg u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_stb (cmp_stb),
        .all_hit (all_hit),
        .clr_stb (clr_stb),
        .flag    (alm_flag)
    );

    // Gate the flag with the enable to form the request.
    always_comb alm_irq = alm_flag && alm_en;

    // R8: the request is never raised while the enable is low.
    always_comb begin
        assert_irq_gated_R8: assert (alm_en || !alm_irq)
            else $error("irq raised without enable");
    end

endmodule

// File: tb/alarm_cmp_tb.sv
module alarm_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] time_bytes = '0;
    logic [23:0] alarm_bytes = '0;
    logic        cmp_stb = 1'b0;
    logic        alm_en = 1'b0;
    logic        clr_stb = 1'b0;
    logic        alm_flag;
    logic        alm_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alarm_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .time_bytes(time_bytes), .alarm_bytes(alarm_bytes),
        .cmp_stb(cmp_stb), .alm_en(alm_en), .clr_stb(clr_stb),
        .alm_flag(alm_flag), .alm_irq(alm_irq)
    );

    // Each vector is {time hh:mm:ss, alarm hh:mm:ss, expected match}.
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {24'h123456, 24'h123456, 1'b1},   // daily, exact
        {24'h123457, 24'h123456, 1'b0},   // seconds differ
        {24'h133456, 24'h123456, 1'b0},   // hours differ
        {24'h073456, 24'hC03456, 1'b1},   // hourly
        {24'h073556, 24'hC03456, 1'b0},   // hourly, minutes differ
        {24'h091156, 24'hFFC056, 1'b1},   // per minute
        {24'h091157, 24'hFFC056, 1'b0},   // per minute, seconds differ
        {24'h235959, 24'hC0C0C0, 1'b1},   // per second
        {24'h000000, 24'h800000, 1'b0},   // 8'h80 is not a wildcard
        {24'h000000, 24'h400000, 1'b0},   // 8'h40 is not a wildcard
        {24'h120056, 24'h12C056, 1'b1},   // only the minute byte is a wildcard
        {24'h000000, 24'h000000, 1'b1}    // midnight
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Pulse the compare strobe with the given bytes for one edge.
    task automatic strobe(input logic [23:0] t, input logic [23:0] a, input logic clr);
        time_bytes = t; alarm_bytes = a; cmp_stb = 1'b1; clr_stb = clr;
        tick();
        cmp_stb = 1'b0; clr_stb = 1'b0;
    endtask

    task automatic clear_flag();
        clr_stb = 1'b1;
        tick();
        clr_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        tick(); tick();
        check("R9 flag after reset", alm_flag, 1'b0);
        check("R9 irq after reset", alm_irq, 1'b0);
        rst_n = 1'b1;
        alm_en = 1'b1;
        tick();

        // R1 R2 R3 R10: walk the vector table.
        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][48:25], VEC[i][24:1], 1'b0);
            check($sformatf("R10/R3 vector %0d flag", i), alm_flag, VEC[i][0]);
            check($sformatf("R8 vector %0d irq", i), alm_irq, VEC[i][0]);
            clear_flag();
            check($sformatf("R6 vector %0d cleared", i), alm_flag, 1'b0);
        end

        // R1: the seconds alarm byte must be compared with the seconds time byte.
        strobe(24'h563412, 24'h123456, 1'b0);
        check("R1 swapped fields do not match", alm_flag, 1'b0);

        // R4: matching bytes without a strobe.
        time_bytes = 24'h101010; alarm_bytes = 24'h101010;
        tick(); tick();
        check("R4 no strobe no flag", alm_flag, 1'b0);

        // R5 and R6: the flag holds across a miss and idle cycles.
        strobe(24'h101010, 24'h101010, 1'b0);
        check("R3 set", alm_flag, 1'b1);
        strobe(24'h101011, 24'h101010, 1'b0);
        check("R5 miss keeps flag", alm_flag, 1'b1);
        repeat (5) tick();
        check("R6 sticky", alm_flag, 1'b1);

        // R7: a clear and a match at the same edge.
        strobe(24'h101010, 24'h101010, 1'b1);
        check("R7 set wins over clear", alm_flag, 1'b1);
        // A clear together with a miss does clear the flag.
        strobe(24'h101011, 24'h101010, 1'b1);
        check("R6 clear with miss", alm_flag, 1'b0);
        strobe(24'h101011, 24'h101010, 1'b0);
        check("R5 miss leaves flag low", alm_flag, 1'b0);

        // R8: the enable gates the request without delay.
        strobe(24'h000001, 24'hC0C0C0, 1'b0);
        alm_en = 1'b0; #1;
        check("R8 irq low with enable low", alm_irq, 1'b0);
        check("R8 flag kept with enable low", alm_flag, 1'b1);
        alm_en = 1'b1; #1;
        check("R8 irq follows enable at once", alm_irq, 1'b1);

        // R9: a reset in mid-run clears the flag.
        tick();
        rst_n = 1'b0;
        tick();
        check("R9 mid-run reset", alm_flag, 1'b0);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        finish_run();
    end

endmodule